// File: doc/BRIEF.md
# Chained Converter Readout Controller

This block is the host side of a three-wire link to a string of identical 14-bit successive-approximation converters wired as a shift chain. It drives the conversion strobe and the serial clock and receives the single serial data line from the converter nearest to it. When a start request arrives, it sets the serial clock to a level that tells every converter whether to announce completion. It then raises the conversion strobe and keeps it high for the whole conversion and the whole readback.

Without the completion announcement, the controller waits a fixed worst-case conversion time before it clocks. With it, the controller waits for the data line to go high, which happens only once every converter in the chain is done. A timeout flags a chain that never answers. The controller then issues exactly as many clock pulses as the frame holds. It samples the data line at each falling clock edge, drops the leading start bit when there is one and splits the stream into one word per converter. The words are sign-extended to 16 bits and presented together with a one-cycle valid strobe, and the conversion strobe falls on that same edge.

Top module: `chain_adc_reader`

## Requirements
- R1: After reset, cnv, sck, results_valid and timeout_err are 0 and every results word is 0.
- R2: The sck level across the rising edge of cnv equals busy_en as captured with the accepted start: low selects a frame without a start bit, high selects a frame with one. sck does not change on that edge.
- R3: Without a start bit, the first rising edge of sck comes exactly CONV_WAIT clock cycles after the rising edge of cnv.
- R4: With a start bit, no falling edge of sck occurs while cnv is high before sdo_in has gone high. The start bit is the first bit sampled, and it is discarded.
- R5: While cnv is high, a frame has exactly 14·N_DEV falling sck edges without a start bit and 14·N_DEV+1 with one.
- R6: sdo_in is sampled on the clock edge that drives sck low. Each word is received MSB first. results[0] holds the first word received (the converter nearest the host) and results[N_DEV-1] holds the last.
- R7: Each 14-bit two's complement word appears in its 16-bit results slot with bit 13 copied into bits 15 and 14 (for example 14'h2000 becomes 16'hE000 and 14'h1FFF becomes 16'h1FFF).
- R8: results_valid is high for exactly one cycle per completed frame, and cnv falls on that same clock edge. cnv stays high through the whole readback.
- R9: If sdo_in stays low for BUSY_TIMEOUT cycles after cnv rises in a frame with a start bit, timeout_err pulses for one cycle on that edge, cnv falls with it, and no results_valid follows.
- R10: Two rising edges of cnv are at least CYCLE_MIN cycles apart. A start accepted earlier than that delays the rise to exactly CYCLE_MIN cycles after the previous rise.
- R11: A start pulse while a frame is in progress has no effect: it causes no extra rise of cnv and no extra results.
- R12: During readback each high and each low phase of sck lasts exactly SCK_HALF clock cycles (SCK_HALF=2 gives a 40 ns period at 100 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion and readback frame (taken only when idle) |
| busy_en | input | 1 | Frame mode for this request: 1 = wait for the start bit, 0 = wait a fixed time |
| sdo_in | input | 1 | Serial data from the nearest converter in the chain |
| cnv | output | 1 | Conversion strobe to all converters |
| sck | output | 1 | Serial clock to all converters |
| results | output | N_DEV×16 | Sign-extended words, index 0 = nearest converter |
| results_valid | output | 1 | One-cycle strobe when results are updated |
| timeout_err | output | 1 | One-cycle strobe when the start bit never arrived |

## Verification
A wrong phase counter or bit counter shows at the ports within one frame. The sck widths, the number of falling edges while cnv is high, or the cycle on which cnv falls all drift from the expected values. A slip of one bit in the receive path moves every word that follows it, so all N_DEV result words mismatch on the next valid strobe. Sign-extension and word-order faults appear only when the words differ in sign and in value, so the scoreboard uses mixed extreme words. A wrong spacing or timeout counter shows up as a rise of cnv or a timeout_err strobe on a cycle other than the computed one.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CONV,
    ST_BUSYW,
    ST_READ
  } rd_state_t;
endpackage

// File: rtl/chain_sck_pacer.sv
module chain_sck_pacer #(
  parameter int SCK_HALF = 2,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_lvl,
  input  logic             lvl,
  input  logic             burst_go,
  input  logic [CNT_W-1:0] burst_len,
  output logic             sck,
  output logic             rd_active,
  output logic             fall_now,
  output logic             burst_done
);
  localparam int PH_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SCK_HALF - 1);

  logic [PH_W-1:0]  ph;
  logic [CNT_W-1:0] bit_idx;
  logic [CNT_W-1:0] len_r;
  logic             ph_end;

  assign ph_end     = (ph == PH_LAST);
  assign fall_now   = rd_active && sck && ph_end;
  assign burst_done = rd_active && !sck && ph_end && (bit_idx == len_r - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck       <= 1'b0;
      rd_active <= 1'b0;
      ph        <= '0;
      bit_idx   <= '0;
      len_r     <= '0;
    end else if (burst_go) begin
      sck       <= 1'b1;
      rd_active <= 1'b1;
      ph        <= '0;
      bit_idx   <= '0;
      len_r     <= burst_len;
    end else if (rd_active) begin
      if (ph_end) begin
        ph <= '0;
        if (sck) begin
          sck <= 1'b0;
        end else if (bit_idx == len_r - 1'b1) begin
          rd_active <= 1'b0;
        end else begin
          sck     <= 1'b1;
          bit_idx <= bit_idx + 1'b1;
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end else if (set_lvl) begin
      sck <= lvl;
    end
  end

  // R12: sck only moves at the end of a full phase while reading
  p_phase_end_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_active) && rd_active && (sck != $past(sck))) |-> (ph == '0));
endmodule

// File: rtl/chain_deser.sv
module chain_deser #(
  parameter int N_DEV  = 3,
  parameter int WORD_W = 14,
  parameter int OUT_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear,
  input  logic                        skip_first,
  input  logic                        take,
  input  logic                        sdo_in,
  input  logic                        capture,
  output logic [N_DEV-1:0][OUT_W-1:0] results,
  output logic                        results_valid
);
  localparam int TOT = N_DEV * WORD_W;

  logic [TOT-1:0]              shreg;
  logic                        drop_next;
  logic [N_DEV-1:0][OUT_W-1:0] words;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      drop_next <= 1'b0;
    end else if (clear) begin
      shreg     <= '0;
      drop_next <= skip_first;
    end else if (take) begin
      if (drop_next) drop_next <= 1'b0;
      else           shreg     <= {shreg[TOT-2:0], sdo_in};
    end
  end

  // first received word sits at the top of the shift register
  for (genvar k = 0; k < N_DEV; k++) begin : g_word
    logic [WORD_W-1:0] raw;
    assign raw      = shreg[(N_DEV-k)*WORD_W-1 -: WORD_W];
    assign words[k] = {{(OUT_W-WORD_W){raw[WORD_W-1]}}, raw};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      results       <= '0;
      results_valid <= 1'b0;
    end else begin
      results_valid <= capture;
      if (capture) results <= words;
    end
  end

  // R8: one-cycle strobe
  p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
    results_valid |=> !results_valid);
  // R4: start bit is never still pending when results are taken
  p_start_dropped_r4: assert property (@(posedge clk) disable iff (rst)
    capture |-> !drop_next);
endmodule

// File: rtl/chain_rd_ctrl.sv
module chain_rd_ctrl
  import chain_rd_pkg::*;
#(
  parameter int N_DEV        = 3,
  parameter int WORD_W       = 14,
  parameter int CONV_WAIT    = 250,
  parameter int BUSY_TIMEOUT = 500,
  parameter int CYCLE_MIN    = 400,
  parameter int CNT_W        = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             busy_en,
  input  logic             sdo_in,
  input  logic             burst_done,
  output logic             cnv,
  output logic             set_lvl,
  output logic             lvl,
  output logic             burst_go,
  output logic [CNT_W-1:0] burst_len,
  output logic             clear,
  output logic             mode_busy,
  output logic             capture,
  output logic             timeout_err
);
  localparam int TOT    = N_DEV * WORD_W;
  localparam int WMAX   = (CONV_WAIT > BUSY_TIMEOUT) ? CONV_WAIT : BUSY_TIMEOUT;
  localparam int WAIT_W = $clog2(WMAX + 1);
  localparam int GAP_W  = $clog2(CYCLE_MIN + 1);
  localparam logic [GAP_W-1:0]  GAP_SAT  = GAP_W'(CYCLE_MIN);
  localparam logic [WAIT_W-1:0] CONV_END = WAIT_W'(CONV_WAIT - 1);
  localparam logic [WAIT_W-1:0] TMO_END  = WAIT_W'(BUSY_TIMEOUT - 1);

  rd_state_t         state;
  logic [WAIT_W-1:0] wait_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic              rise_ok, conv_done, busy_seen, tmo_hit;

  assign rise_ok   = (state == ST_SETUP) && (gap_cnt >= GAP_SAT);
  assign conv_done = (state == ST_CONV) && (wait_cnt == CONV_END);
  assign busy_seen = (state == ST_BUSYW) && sdo_in;
  assign tmo_hit   = (state == ST_BUSYW) && !sdo_in && (wait_cnt == TMO_END);
  assign set_lvl   = ((state == ST_IDLE) && start) || tmo_hit;
  assign lvl       = (state == ST_IDLE) ? busy_en : 1'b0;
  assign clear     = rise_ok;
  assign burst_go  = conv_done || busy_seen;
  assign capture   = (state == ST_READ) && burst_done;
  assign burst_len = mode_busy ? CNT_W'(TOT + 1) : CNT_W'(TOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnv         <= 1'b0;
      mode_busy   <= 1'b0;
      wait_cnt    <= '0;
      gap_cnt     <= GAP_SAT;
      timeout_err <= 1'b0;
    end else begin
      timeout_err <= 1'b0;
      if (rise_ok)                gap_cnt <= GAP_W'(1);
      else if (gap_cnt < GAP_SAT) gap_cnt <= gap_cnt + 1'b1;
      unique case (state)
        ST_IDLE: if (start) begin
          mode_busy <= busy_en;
          state     <= ST_SETUP;
        end
        ST_SETUP: if (rise_ok) begin
          cnv      <= 1'b1;
          wait_cnt <= '0;
          state    <= mode_busy ? ST_BUSYW : ST_CONV;
        end
        ST_CONV: begin
          wait_cnt <= wait_cnt + 1'b1;
          if (conv_done) state <= ST_READ;
        end
        ST_BUSYW: begin
          wait_cnt <= wait_cnt + 1'b1;
          if (busy_seen) begin
            state <= ST_READ;
          end else if (tmo_hit) begin
            timeout_err <= 1'b1;
            cnv         <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        ST_READ: if (burst_done) begin
          cnv   <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: a timeout strobe always ends the frame
  p_timeout_ends_r9: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (!cnv && state == ST_IDLE));
  // R11: a new request never disturbs a frame in progress
  p_mode_held_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(cnv) && cnv) |-> $stable(mode_busy));
endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader #(
  parameter int N_DEV        = 3,
  parameter int WORD_W       = 14,
  parameter int OUT_W        = 16,
  parameter int SCK_HALF     = 2,
  parameter int CONV_WAIT    = 250,
  parameter int BUSY_TIMEOUT = 500,
  parameter int CYCLE_MIN    = 400
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        busy_en,
  input  logic                        sdo_in,
  output logic                        cnv,
  output logic                        sck,
  output logic [N_DEV-1:0][OUT_W-1:0] results,
  output logic                        results_valid,
  output logic                        timeout_err
);
  localparam int TOT   = N_DEV * WORD_W;
  localparam int CNT_W = $clog2(TOT + 2);
  localparam int GAP_W = $clog2(CYCLE_MIN + 1);

  logic             set_lvl, lvl, burst_go, clear, mode_busy, capture;
  logic             rd_active, fall_now, burst_done;
  logic [CNT_W-1:0] burst_len;

  chain_rd_ctrl #(
    .N_DEV(N_DEV), .WORD_W(WORD_W), .CONV_WAIT(CONV_WAIT),
    .BUSY_TIMEOUT(BUSY_TIMEOUT), .CYCLE_MIN(CYCLE_MIN), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .busy_en(busy_en), .sdo_in(sdo_in),
    .burst_done(burst_done), .cnv(cnv), .set_lvl(set_lvl), .lvl(lvl),
    .burst_go(burst_go), .burst_len(burst_len), .clear(clear),
    .mode_busy(mode_busy), .capture(capture), .timeout_err(timeout_err)
  );

  chain_sck_pacer #(.SCK_HALF(SCK_HALF), .CNT_W(CNT_W)) u_pacer (
    .clk(clk), .rst(rst), .set_lvl(set_lvl), .lvl(lvl), .burst_go(burst_go),
    .burst_len(burst_len), .sck(sck), .rd_active(rd_active),
    .fall_now(fall_now), .burst_done(burst_done)
  );

  chain_deser #(.N_DEV(N_DEV), .WORD_W(WORD_W), .OUT_W(OUT_W)) u_deser (
    .clk(clk), .rst(rst), .clear(clear), .skip_first(mode_busy),
    .take(fall_now), .sdo_in(sdo_in), .capture(capture),
    .results(results), .results_valid(results_valid)
  );

  // spacing monitor for R10, independent of the controller's own counter
  logic             cnv_q;
  logic [GAP_W-1:0] chk_gap;
  always_ff @(posedge clk) begin
    if (rst) begin
      cnv_q   <= 1'b0;
      chk_gap <= GAP_W'(CYCLE_MIN);
    end else begin
      cnv_q <= cnv;
      if (cnv && !cnv_q)                   chk_gap <= GAP_W'(1);
      else if (chk_gap < GAP_W'(CYCLE_MIN)) chk_gap <= chk_gap + 1'b1;
    end
  end

  p_cnv_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv) |-> (chk_gap >= GAP_W'(CYCLE_MIN)));
  p_sck_steady_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv) |-> $stable(sck));
  p_cnv_in_read_r5: assert property (@(posedge clk) disable iff (rst)
    rd_active |-> cnv);
  p_valid_cnv_fall_r8: assert property (@(posedge clk) disable iff (rst)
    results_valid |-> $fell(cnv));
  p_no_valid_on_tmo_r9: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> !results_valid);
endmodule

// File: tb/chain_adc_reader_tb.sv
`timescale 1ns/1ps
module chain_adc_reader_tb;
  localparam int N_DEV = 3, WORD_W = 14, OUT_W = 16, SCK_HALF = 2;
  localparam int CONV_WAIT = 250, BUSY_TIMEOUT = 500, CYCLE_MIN = 400;
  localparam int TOT = N_DEV * WORD_W;
  localparam int PER = 10;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, busy_en = 1'b0, sdo_in = 1'b0;
  logic cnv, sck, results_valid, timeout_err;
  logic [N_DEV-1:0][OUT_W-1:0] results;

  chain_adc_reader #(
    .N_DEV(N_DEV), .WORD_W(WORD_W), .OUT_W(OUT_W), .SCK_HALF(SCK_HALF),
    .CONV_WAIT(CONV_WAIT), .BUSY_TIMEOUT(BUSY_TIMEOUT), .CYCLE_MIN(CYCLE_MIN)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .busy_en(busy_en), .sdo_in(sdo_in),
    .cnv(cnv), .sck(sck), .results(results), .results_valid(results_valid),
    .timeout_err(timeout_err)
  );

  always #(PER/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [OUT_W-1:0] exp_q[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [OUT_W-1:0] sext(input logic [WORD_W-1:0] w);
    return {{(OUT_W-WORD_W){w[WORD_W-1]}}, w};
  endfunction

  // chain model
  logic [WORD_W-1:0] mw[N_DEV];
  int  m_lat = 100;
  bit  m_nodone = 0;
  logic [TOT:0] stream = '0;
  bit  bsel = 0;
  bit  sdo_high_seen = 0;

  initial forever begin
    @(posedge cnv);
    bsel = sck;
    sdo_high_seen = 0;
    repeat (m_lat) @(negedge clk);
    if (!m_nodone && cnv) begin
      if (bsel) stream = {1'b1, mw[0], mw[1], mw[2]};
      else      stream = {mw[0], mw[1], mw[2], 1'b0};
      sdo_in = stream[TOT];
      sdo_high_seen = sdo_in;
    end
  end
  always @(negedge sck) begin
    #2;
    if (cnv) begin
      stream = {stream[TOT-1:0], 1'b0};
      sdo_in = stream[TOT];
    end
  end
  always @(negedge cnv) begin
    #2;
    stream = '0;
    sdo_in = 1'b0;
  end
  always @(posedge sdo_in) sdo_high_seen = 1;

  // port monitors
  bit    exp_mode = 0, chk_gap_exact = 0;
  int    n_rises = 0, n_valid = 0, n_err = 0;
  int    falls = 0, early_falls = 0, width_bad = 0;
  bit    have_r = 0, have_f = 0, first_r = 0;
  time   t_rise = 0, t_prev = 0, t_first_sck = 0, t_r = 0, t_f = 0, t_err = 0;

  always @(posedge cnv) begin
    t_prev = t_rise;
    t_rise = $time;
    n_rises++;
    check(sck == exp_mode, "R2 sck level at cnv rise", sck, exp_mode);
    if (chk_gap_exact)
      check((t_rise - t_prev) / PER == CYCLE_MIN, "R10 cnv rise spacing",
            (t_rise - t_prev) / PER, CYCLE_MIN);
    falls = 0; early_falls = 0; width_bad = 0;
    have_r = 0; have_f = 0; first_r = 0;
  end
  always @(posedge sck) begin
    #1;
    if (cnv) begin
      if (!first_r) begin first_r = 1; t_first_sck = $time; end
      if (have_f && ($time - t_f) != SCK_HALF * PER) width_bad++;
      t_r = $time; have_r = 1;
    end
  end
  always @(negedge sck) begin
    #1;
    if (cnv) begin
      falls++;
      if (bsel && !sdo_high_seen) early_falls++;
      if (have_r && ($time - t_r) != SCK_HALF * PER) width_bad++;
      t_f = $time; have_f = 1;
    end
  end
  always @(posedge timeout_err) begin t_err = $time; n_err++; end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (results_valid) begin
      n_valid++;
      check(cnv == 1'b0, "R8 cnv low with valid", cnv, 0);
      for (int k = 0; k < N_DEV; k++) begin
        logic [OUT_W-1:0] e;
        if (exp_q.size() == 0) begin
          check(0, "R11 unexpected results", results[k], 0);
        end else begin
          e = exp_q.pop_front();
          check(results[k] == e, "R6,R7 result word", results[k], e);
        end
      end
      @(negedge clk);
      check(results_valid == 1'b0, "R8 valid single cycle", results_valid, 0);
    end
  end

  task automatic run_frame(input bit busy, input logic [WORD_W-1:0] a, b, c,
                           input int lat, input bit nodone, input bit poke);
    int err_before;
    mw[0] = a; mw[1] = b; mw[2] = c;
    m_lat = lat; m_nodone = nodone; exp_mode = busy;
    err_before = n_err;
    if (!nodone) begin
      exp_q.push_back(sext(a)); exp_q.push_back(sext(b)); exp_q.push_back(sext(c));
    end
    @(negedge clk); start = 1'b1; busy_en = busy;
    @(negedge clk); start = 1'b0;
    wait (cnv === 1'b1);
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1; busy_en = ~busy;
      @(negedge clk); start = 1'b0;
    end
    wait (cnv === 1'b0);
    repeat (3) @(negedge clk);
    if (nodone) begin
      check(n_err == err_before + 1, "R9 timeout strobe", n_err - err_before, 1);
      check((t_err - t_rise) / PER == BUSY_TIMEOUT, "R9 timeout cycle",
            (t_err - t_rise) / PER, BUSY_TIMEOUT);
      check(falls == 0, "R9 no clocks after timeout", falls, 0);
    end else begin
      check(falls == (busy ? TOT + 1 : TOT), "R5 falling edge count", falls, busy ? TOT + 1 : TOT);
      check(width_bad == 0, "R12 sck phase width", width_bad, 0);
      check(n_err == err_before, "R9 no spurious timeout", n_err - err_before, 0);
      if (busy)
        check(early_falls == 0, "R4 clock before start bit", early_falls, 0);
      else
        check((t_first_sck - t_rise) / PER == CONV_WAIT, "R3 wait before clocks",
              (t_first_sck - t_rise) / PER, CONV_WAIT);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cnv == 0, "R1 cnv after reset", cnv, 0);
    check(sck == 0, "R1 sck after reset", sck, 0);
    check(results_valid == 0, "R1 valid after reset", results_valid, 0);
    check(timeout_err == 0, "R1 timeout after reset", timeout_err, 0);
    check(results == '0, "R1 results after reset", results, 0);

    // fixed-wait frames, extreme and mixed words
    run_frame(1'b0, 14'h1FFF, 14'h2000, 14'h0001, 200, 0, 0);
    run_frame(1'b0, 14'h1555, 14'h3001, 14'h0800, 150, 0, 1);   // R11 poke
    // start-bit frames
    run_frame(1'b1, 14'h3FFF, 14'h0000, 14'h2AAA, 120, 0, 0);
    run_frame(1'b1, 14'h0ABC, 14'h3E01, 14'h1F0F, 10, 0, 1);    // R11 poke
    chk_gap_exact = 1;                                         // R10 early start
    run_frame(1'b1, 14'h2001, 14'h1FFE, 14'h3555, 10, 0, 0);
    chk_gap_exact = 0;
    // R9 chain never answers
    run_frame(1'b1, 14'h0000, 14'h0000, 14'h0000, 0, 1, 0);
    run_frame(1'b0, 14'h0F0F, 14'h30F0, 14'h2222, 240, 0, 0);

    repeat (20) @(negedge clk);
    check(n_rises == 7, "R11 cnv rise count", n_rises, 7);
    check(n_valid == 6, "R11 valid count", n_valid, 6);
    check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule